// File: doc/BRIEF.md
# Serial EEPROM Page-Write Slave

This block answers a three-wire serial host (select, serial clock, data in) as a word-organised serial memory that knows one command: page write. The host raises select and clocks in a four-bit command code. It follows with a six-bit word address and then any number of 16-bit data words, each bit taken on a rising serial clock, most significant bit first. Completed words collect in a four-slot page buffer. The two low address bits step after every word and wrap inside the page. The upper address bits stay fixed.

When select drops after at least one complete word, a timed programming cycle starts. At its end the block copies every buffer slot that received a word into an internal register-array memory. While that cycle runs, the host can raise select and poll the data-out line: 0 means busy, and 1 means the write is done and a new command is accepted. All serial inputs are resynchronised into the system clock domain. A combinational read port lets neighbouring logic inspect the array.

Top module: `mw_page_slave`

## Requirements
- R1: While select is high, each rising serial clock takes one bit from data-in. A frame is the code 0,1,1,1, then address bits A5..A0, then data words D15..D0. A frame whose code differs writes nothing.
- R2: The first complete word goes to the frame's address. After each complete word only the two low address bits increment by one, and the upper four bits stay unchanged.
- R3: After low bits 11 the next word goes to low bits 00 of the same page. With six words sent, the fifth word replaces the first one and the sixth replaces the second.
- R4: At the end of programming, only the page slots that received a word in the frame are written into the array. The other words of that page keep their previous contents.
- R5: If select falls before one complete word has arrived, no programming cycle starts and the status output stays undriven. Trailing bits that do not form a whole word are discarded.
- R6: If program-enable is low when the select fall is seen, the frame is dropped: nothing is written and no status is driven.
- R7: Programming starts on the third system clock edge after select falls at the pin. It lasts PROG_CYCLES clocks, and the array changes only on its last clock. Before then, the read port still returns the old data.
- R8: dout_oe_o=1 means the block drives dout_o. It is driven only while synchronised select is high after a started write, and it stays so until select falls while ready. While driven, dout_o=0 means busy and 1 means ready. When not driven, dout_oe_o=0 and dout_o=0, as it is throughout command shifting.
- R9: While programming runs, serial clock and data-in are ignored, so a frame sent during that time writes nothing.
- R10: After reset the status output is undriven and every array word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Serial select, active high, asynchronous to clk |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| sdi_i | input | 1 | Serial data in |
| prog_en_i | input | 1 | Program enable, must be high at select fall |
| rd_addr_i | input | ADDR_W | Array read address |
| dout_o | output | 1 | Status bit: 0 busy, 1 ready |
| dout_oe_o | output | 1 | Drive enable for dout_o (0 = high impedance) |
| rd_data_o | output | WORD_W | Array word at rd_addr_i |

## Verification
A wrong slot pointer or address latch shows as a misplaced or missing word on the read port. It appears on the clock edge that ends programming, which is PROG_CYCLES plus three clocks after select falls. A stuck or mis-timed programming timer shows at once on the polled status bit, because the bench compares dout_o and dout_oe_o against its model on every clock. A status flag that is left set or cleared wrongly shows the next time select rises. A lost or extra write-enable slot shows as a page word that changes when it must keep its value, and directed reads of the neighbouring words expose it.

// File: rtl/mw_pkg.sv
// Shared constants and types for the serial page-write slave.
// Assumes a four-bit command code shifted in most significant bit first.
package mw_pkg;
    localparam int HDR_W = 4;
    localparam logic [HDR_W-1:0] HDR_CODE = 4'b0111;

    // Which field of a frame the next serial bit belongs to.
    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;
endpackage

// File: rtl/mw_sync.sv
// Multi-bit input synchroniser: a chain of STAGES flops per bit.
// Assumes each bit is independent and slow next to clk (no bus coherency).
module mw_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mw_frame.sv
// Frame receiver: decodes command code, address and data words from
// synchronised serial events and fills a page buffer with a wrapping pointer.
// Assumes WORD_W >= ADDR_W >= SLOT_BITS >= 2 and that nothing moves while busy.
module mw_frame
    import mw_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 6,
    parameter int SLOT_BITS = 2,
    localparam int SLOTS    = 1 << SLOT_BITS,
    localparam int BASE_W   = ADDR_W - SLOT_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_s,
    input  logic                    cs_fall,
    input  logic                    sk_rise,
    input  logic                    di_s,
    input  logic                    pe_s,
    input  logic                    busy,
    input  logic                    commit,
    output logic                    start,
    output logic [SLOTS*WORD_W-1:0] page_o,
    output logic [SLOTS-1:0]        valid_o,
    output logic [BASE_W-1:0]       base_o
);
    localparam int BC_W = $clog2(WORD_W);
    localparam logic [BC_W-1:0] HDR_LAST  = BC_W'(HDR_W - 1);
    localparam logic [BC_W-1:0] ADDR_LAST = BC_W'(ADDR_W - 1);
    localparam logic [BC_W-1:0] WORD_LAST = BC_W'(WORD_W - 1);

    phase_e                 ph;
    logic [BC_W-1:0]        bcnt;
    logic [HDR_W-1:0]       hdr_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [WORD_W-2:0]      word_q;
    logic [SLOT_BITS-1:0]   ptr_q;
    logic [WORD_W-1:0]      page_q [SLOTS];
    logic [SLOTS-1:0]       valid_q;
    logic [ADDR_W-1:0]      next_addr;
    logic                   hdr_ok;

    // Address register value after the current bit is taken.
    assign next_addr = {addr_q[ADDR_W-2:0], di_s};
    assign hdr_ok    = (hdr_q == HDR_CODE);

    // Programming may begin on a select fall with a good, non-empty frame.
    assign start = cs_fall & ~busy & (ph == PH_DATA) & hdr_ok
                 & (|valid_q) & pe_s;

    // Frame field decoding, word assembly and page slot filling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_HDR;
            bcnt    <= '0;
            hdr_q   <= '0;
            addr_q  <= '0;
            word_q  <= '0;
            ptr_q   <= '0;
            valid_q <= '0;
            for (int s = 0; s < SLOTS; s++) begin
                page_q[s] <= '0;
            end
        end else if (busy) begin
            if (commit) begin
                valid_q <= '0;
            end
        end else if (!cs_s) begin
            ph   <= PH_HDR;
            bcnt <= '0;
            if (!start) begin
                valid_q <= '0;
            end
        end else if (sk_rise) begin
            case (ph)
                PH_HDR: begin
                    hdr_q <= {hdr_q[HDR_W-2:0], di_s};
                    if (bcnt == HDR_LAST) begin
                        bcnt <= '0;
                        ph   <= PH_ADDR;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    addr_q <= next_addr;
                    if (bcnt == ADDR_LAST) begin
                        bcnt  <= '0;
                        ph    <= PH_DATA;
                        ptr_q <= next_addr[SLOT_BITS-1:0];
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (hdr_ok) begin
                        word_q <= {word_q[WORD_W-3:0], di_s};
                        if (bcnt == WORD_LAST) begin
                            page_q[ptr_q]  <= {word_q, di_s};
                            valid_q[ptr_q] <= 1'b1;
                            ptr_q          <= ptr_q + 1'b1;
                            bcnt           <= '0;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                end
                default: ph <= PH_HDR;
            endcase
        end
    end

    // Flatten the page buffer for the programming stage.
    for (genvar g = 0; g < SLOTS; g++) begin : g_page
        assign page_o[g*WORD_W +: WORD_W] = page_q[g];
    end

    assign valid_o = valid_q;
    assign base_o  = addr_q[ADDR_W-1:SLOT_BITS];
endmodule

// File: rtl/mw_prog.sv
// Programming stage: self-timed cycle counter and register-array memory.
// Commits the marked page slots on the last cycle; read port is combinational.
// Assumes PROG_CYCLES >= 2 and that page inputs are held while busy.
module mw_prog #(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 6,
    parameter int SLOT_BITS   = 2,
    parameter int PROG_CYCLES = 40,
    localparam int SLOTS      = 1 << SLOT_BITS,
    localparam int BASE_W     = ADDR_W - SLOT_BITS,
    localparam int DEPTH      = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [SLOTS*WORD_W-1:0] page_i,
    input  logic [SLOTS-1:0]        valid_i,
    input  logic [BASE_W-1:0]       base_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    output logic                    busy_o,
    output logic                    commit_o,
    output logic [WORD_W-1:0]       rd_data_o
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q;
    logic [WORD_W-1:0] mem_q [DEPTH];

    // Count down the programming cycle after a start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LOAD;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign commit_o = busy_q & (cnt_q == '0);

    // Write the marked page slots into the array on the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem_q[a] <= '0;
            end
        end else if (commit_o) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (valid_i[s]) begin
                    mem_q[{base_i, SLOT_BITS'(s)}] <= page_i[s*WORD_W +: WORD_W];
                end
            end
        end
    end

    assign busy_o    = busy_q;
    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/mw_page_slave.sv
// Top of the serial page-write slave: synchronises the pins, detects edges,
// connects receiver and programming stage, and drives the busy/ready status.
// Assumes the host holds each serial level for at least three clk periods.
module mw_page_slave #(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 6,
    parameter int SLOT_BITS   = 2,
    parameter int PROG_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              prog_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              dout_o,
    output logic              dout_oe_o,
    output logic [WORD_W-1:0] rd_data_o
);
    localparam int SLOTS  = 1 << SLOT_BITS;
    localparam int BASE_W = ADDR_W - SLOT_BITS;

    logic [3:0]              pins_s;
    logic                    cs_s, sk_s, di_s, pe_s;
    logic                    cs_d, sk_d;
    logic                    cs_fall, sk_rise;
    logic                    start, busy, commit, stat_q;
    logic [SLOTS*WORD_W-1:0] page;
    logic [SLOTS-1:0]        valid;
    logic [BASE_W-1:0]       base;

    mw_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({prog_en_i, sdi_i, sclk_i, sel_i}),
        .q     (pins_s)
    );

    assign cs_s = pins_s[0];
    assign sk_s = pins_s[1];
    assign di_s = pins_s[2];
    assign pe_s = pins_s[3];

    // Previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d <= 1'b0;
            sk_d <= 1'b0;
        end else begin
            cs_d <= cs_s;
            sk_d <= sk_s;
        end
    end

    assign cs_fall = cs_d & ~cs_s;
    assign sk_rise = sk_s & ~sk_d & cs_s;

    mw_frame #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SLOT_BITS(SLOT_BITS)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .cs_fall (cs_fall),
        .sk_rise (sk_rise),
        .di_s    (di_s),
        .pe_s    (pe_s),
        .busy    (busy),
        .commit  (commit),
        .start   (start),
        .page_o  (page),
        .valid_o (valid),
        .base_o  (base)
    );

    mw_prog #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SLOT_BITS(SLOT_BITS),
              .PROG_CYCLES(PROG_CYCLES)) u_prog (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .page_i    (page),
        .valid_i   (valid),
        .base_i    (base),
        .rd_addr_i (rd_addr_i),
        .busy_o    (busy),
        .commit_o  (commit),
        .rd_data_o (rd_data_o)
    );

    // Status is armed by a started write and disarmed by a select fall when ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (start) begin
            stat_q <= 1'b1;
        end else if (cs_fall && !busy) begin
            stat_q <= 1'b0;
        end
    end

    assign dout_oe_o = stat_q & cs_s;
    assign dout_o    = dout_oe_o & ~busy;
endmodule

// File: rtl/mw_page_chk.sv
// Checker for the page-write slave, attached to the top by bind.
// Relates receiver state, timer state and the status pins over time.
module mw_page_chk #(
    parameter int SLOTS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             commit,
    input logic [SLOTS-1:0] valid,
    input logic             pe_s,
    input logic             dout_o,
    input logic             dout_oe_o
);
    // R9
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !commit |=> $stable(valid));

    // R7
    prog_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);

    // R4
    commit_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> valid != '0);

    // R5
    no_empty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(valid) != '0);

    // R6
    enable_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(pe_s));

    // R8
    busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe_o && busy |-> !dout_o);
endmodule

bind mw_page_slave mw_page_chk #(.SLOTS(SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .commit    (commit),
    .valid     (valid),
    .pe_s      (pe_s),
    .dout_o    (dout_o),
    .dout_oe_o (dout_oe_o)
);

// File: tb/mw_page_slave_test.sv
module mw_page_slave_test;
    localparam int PROG = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, sclk = 1'b0, sdi = 1'b0, pe = 1'b1;
    logic [5:0] sw_addr = '0, dir_addr = '0;
    logic       sweep = 1'b1;
    logic [5:0] rd_addr;
    logic       dout, dout_oe;
    logic [15:0] rd_data;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [15:0] words [8];

    assign rd_addr = sweep ? sw_addr : dir_addr;

    always #5 clk = ~clk;

    mw_page_slave #(.PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
        .prog_en_i(pe), .rd_addr_i(rd_addr), .dout_o(dout),
        .dout_oe_o(dout_oe), .rd_data_o(rd_data)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Behavioural reference model, one update per clock.
    bit [3:0] m1, m2;
    bit mcsd, mskd, mbusy, mstat;
    bit [3:0] mval;
    int mph, mbc, mhdr, maddr, mword, mptr, mcnt;
    int mpage [4];
    int mmem [64];
    bit f_fall, f_rise, f_comm, f_go, f_was, f_di;

    always @(posedge clk) begin
        if (!rst_n) begin
            m1 = 0; m2 = 0; mcsd = 0; mskd = 0; mbusy = 0; mstat = 0; mval = 0;
            mph = 0; mbc = 0; mhdr = 0; maddr = 0; mword = 0; mptr = 0; mcnt = 0;
            for (int i = 0; i < 4; i++) mpage[i] = 0;
            for (int i = 0; i < 64; i++) mmem[i] = 0;
        end else begin
            f_fall = mcsd && !m2[0];
            f_rise = m2[1] && !mskd && m2[0];
            f_comm = mbusy && (mcnt == 0);
            f_was  = mbusy;
            f_go   = f_fall && !mbusy && mph == 2 && mhdr == 7 && mval != 0 && m2[3];
            if (f_comm)
                for (int s = 0; s < 4; s++)
                    if (mval[s]) mmem[(maddr >> 2) * 4 + s] = mpage[s];
            if (f_go) begin
                mbusy = 1; mcnt = PROG - 1;
            end else if (mbusy) begin
                if (mcnt == 0) mbusy = 0; else mcnt--;
            end
            if (f_was) begin
                if (f_comm) mval = 0;
            end else if (!m2[0]) begin
                mph = 0; mbc = 0;
                if (!f_go) mval = 0;
            end else if (f_rise) begin
                f_di = m2[2];
                if (mph == 0) begin
                    mhdr = ((mhdr << 1) | f_di) & 15; mbc++;
                    if (mbc == 4) begin mbc = 0; mph = 1; end
                end else if (mph == 1) begin
                    maddr = ((maddr << 1) | f_di) & 63; mbc++;
                    if (mbc == 6) begin mbc = 0; mph = 2; mptr = maddr & 3; end
                end else if (mhdr == 7) begin
                    mword = ((mword << 1) | f_di) & 16'hFFFF; mbc++;
                    if (mbc == 16) begin
                        mpage[mptr] = mword; mval[mptr] = 1;
                        mptr = (mptr + 1) & 3; mbc = 0;
                    end
                end
            end
            if (f_go) mstat = 1;
            else if (f_fall && !f_was) mstat = 0;
            mcsd = m2[0]; mskd = m2[1];
            m2 = m1; m1 = {pe, sdi, sclk, sel};
        end
    end

    // Per-clock comparison of status pins and the read port against the model.
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            chk("R8 status enable", dout_oe, int'(mstat && m2[0]));
            chk("R8 status value", dout, int'(mstat && m2[0] && !mbusy));
            chk("R7 array word", rd_data, mmem[rd_addr]);
            if (sweep) sw_addr <= sw_addr + 1'b1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b; sclk = 1'b0; tick(4);
        sclk = 1'b1; tick(4);
        sclk = 1'b0;
    endtask

    task automatic send_val(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic frame(input logic [3:0] hdr, input logic [5:0] a,
                         input int nw, input int extra);
        sel = 1'b1; tick(4);
        send_val(16'(hdr), 4);
        send_val(16'(a), 6);
        for (int k = 0; k < nw; k++) send_val(words[k], 16);
        for (int k = 0; k < extra; k++) send_bit(k[0]);
        tick(2);
        sel = 1'b0; tick(6);
    endtask

    task automatic wait_prog();
        sel = 1'b1; tick(PROG + 20);
        sel = 1'b0; tick(6);
    endtask

    task automatic rd(input logic [5:0] a, input string tag, input int exp);
        dir_addr = a; sweep = 1'b0; tick(1);
        chk(tag, rd_data, exp);
        sweep = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R10 reset state
        chk("R10 oe after reset", dout_oe, 0);
        rd(6'h05, "R10 word 05 after reset", 0);
        rd(6'h3F, "R10 word 3F after reset", 0);

        // R1 / R7 / R8: single word with polling
        words[0] = 16'hA5A5;
        frame(4'b0111, 6'h05, 1, 0);
        rd(6'h05, "R7 word unchanged mid-programming", 0);
        sel = 1'b1; tick(4);
        chk("R8 oe while busy", dout_oe, 1);
        chk("R8 busy reads 0", dout, 0);
        tick(PROG + 20);
        chk("R8 ready reads 1", dout, 1);
        sel = 1'b0; tick(6);
        chk("R8 undriven after ready fall", dout_oe, 0);
        rd(6'h05, "R1 word 05", 16'hA5A5);
        rd(6'h04, "R2 word 04 untouched", 0);
        rd(6'h06, "R2 word 06 untouched", 0);

        // R2 / R3 / R4: three words starting at low bits 10
        words[0] = 16'h1111; words[1] = 16'h2222; words[2] = 16'h3333;
        frame(4'b0111, 6'h2E, 3, 0);
        wait_prog();
        rd(6'h2E, "R2 first word", 16'h1111);
        rd(6'h2F, "R2 second word", 16'h2222);
        rd(6'h2C, "R3 wrapped word", 16'h3333);
        rd(6'h2D, "R4 unmarked slot", 0);

        // R3: six words overwrite the first two
        for (int k = 0; k < 6; k++) words[k] = 16'h1A01 + 16'(k);
        frame(4'b0111, 6'h10, 6, 0);
        wait_prog();
        rd(6'h10, "R3 fifth over first", 16'h1A05);
        rd(6'h11, "R3 sixth over second", 16'h1A06);
        rd(6'h12, "R3 third kept", 16'h1A03);
        rd(6'h13, "R3 fourth kept", 16'h1A04);

        // R5: partial word only
        frame(4'b0111, 6'h20, 0, 10);
        sel = 1'b1; tick(4);
        chk("R5 no status after partial", dout_oe, 0);
        sel = 1'b0; tick(PROG + 20);
        rd(6'h20, "R5 partial discarded", 0);

        // R5: one word plus trailing bits
        words[0] = 16'hBEEF;
        frame(4'b0111, 6'h21, 1, 7);
        wait_prog();
        rd(6'h21, "R5 complete word kept", 16'hBEEF);
        rd(6'h22, "R5 trailing bits dropped", 0);

        // R6: program enable low
        pe = 1'b0;
        words[0] = 16'h7777;
        frame(4'b0111, 6'h30, 1, 0);
        sel = 1'b1; tick(4);
        chk("R6 no status without enable", dout_oe, 0);
        sel = 1'b0; tick(PROG + 20);
        rd(6'h30, "R6 no write without enable", 0);
        pe = 1'b1;

        // R1: wrong command code
        words[0] = 16'h5555;
        frame(4'b0110, 6'h31, 1, 0);
        tick(PROG + 20);
        rd(6'h31, "R1 bad code ignored", 0);

        // R9: frame during programming
        words[0] = 16'hCAFE;
        frame(4'b0111, 6'h38, 1, 0);
        words[0] = 16'hDEAD;
        frame(4'b0111, 6'h39, 1, 0);
        wait_prog();
        rd(6'h38, "R9 first frame written", 16'hCAFE);
        rd(6'h39, "R9 busy frame ignored", 0);

        tick(4);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R7 watchdog got hung expected completion");
            summary();
            $finish;
        end
    end
endmodule